// File: doc/BRIEF.md
# Credit-Based Flow-Controlled Link

This block joins a producer and a consumer through a link whose forward and return directions each take a fixed number of clock cycles, `LAT`. The transmit side keeps a count of the receive-buffer slots it believes are free, and it accepts a new item from its producer only while that count is above zero. The receive side keeps arriving items in a FIFO of `2*LAT` entries. Each item its consumer takes off the FIFO releases one credit, which travels back to the transmit side over the delayed return path.

The two sides share no control signal other than the credit pulses. The producer sees a valid/ready port that drops ready once it has used every credit. The consumer sees a valid/ready port on the FIFO head. Because the buffer matches the round trip, a consumer that takes an item every cycle lets the producer send every cycle.

Top module: `credit_link`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `out_valid` is 0, and the transmit side holds 2*LAT credits.
- R2: `in_ready` is 0 exactly when no credit is held. With the consumer stalled, exactly 2*LAT items are accepted before `in_ready` stays low.
- R3: The receive FIFO of 2*LAT entries is never written while full.
- R4: An item accepted in cycle c (`in_valid` and `in_ready` both 1 at the rising edge that ends cycle c) first shows on `out_valid`/`out_data` in cycle c+LAT, when the FIFO was empty.
- R5: When the credit count is zero and the consumer pops one item in cycle p, `in_ready` stays 0 through cycle p+LAT-1 and is 1 in cycle p+LAT.
- R6: An accept and a returning credit in the same cycle leave the credit count unchanged. With the producer always valid and the consumer always ready, `in_ready` never drops and one item leaves per cycle once the first has arrived.
- R7: Every accepted item reaches the consumer exactly once, in acceptance order, with its data unchanged.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged in the next cycle.
- R9: The credit count never exceeds 2*LAT. After any traffic has fully drained, the credit count returns to 2*LAT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers an item |
| in_ready | output | 1 | A credit is held, so the item is taken |
| in_data | input | DATA_W | Producer item |
| out_valid | output | 1 | The receive FIFO holds an item |
| out_ready | input | 1 | Consumer takes the head item |
| out_data | output | DATA_W | Head item of the receive FIFO |

## Verification
The embedded assertions check on every cycle that the credit count stays at or below 2*LAT, that a simultaneous accept and credit return leave the count unchanged, that the FIFO is never written while full, and that a stalled head item holds still. Only the bench scenarios can show the cycle counts: the forward latency, the LAT-cycle restart after a full stall, and the unbroken throughput under continuous traffic. The bench scenarios also show end-to-end ordering against a scoreboard and that credits return to their full count after irregular valid/ready patterns.

// File: rtl/credit_link_pkg.sv
package credit_link_pkg;
  function automatic int count_bits(input int max_value);
    return $clog2(max_value + 1);
  endfunction
endpackage

// File: rtl/link_pipe.sv
module link_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  generate
    if (STAGES == 0) begin : g_wire
      assign d_out = d_in;
    end else begin : g_regs
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d_in;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign d_out = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/credit_sender.sv
module credit_sender #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic credit_ret,
  output logic send
);
  logic [CNT_W-1:0] credits;

  assign in_ready = (credits != '0);
  assign send     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      credits <= CNT_W'(DEPTH);
    end else begin
      case ({send, credit_ret})
        2'b10:   credits <= credits - 1'b1;
        2'b01:   credits <= credits + 1'b1;
        default: credits <= credits;
      endcase
    end
  end

  assert_credit_cap_R9: assert property (@(posedge clk) disable iff (rst)
    credits <= CNT_W'(DEPTH));

  assert_send_and_return_R6: assert property (@(posedge clk) disable iff (rst)
    (send && credit_ret) |=> $stable(credits));

  assert_send_consumes_R2: assert property (@(posedge clk) disable iff (rst)
    (send && !credit_ret) |=> (credits == $past(credits) - 1'b1));
endmodule

// File: rtl/credit_receiver.sv
module credit_receiver #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              pop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = credit_link_pkg::count_bits(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  fill;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (fill != '0);
  assign out_data  = mem[rd_ptr];
  assign pop       = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (pop)   rd_ptr <= bump(rd_ptr);
      case ({wr_en, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (fill < CNT_W'(DEPTH)));

  assert_head_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/credit_link.sv
module credit_link #(
  parameter int DATA_W = 8,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int DEPTH = 2 * LAT;
  localparam int HOPS  = LAT - 1;
  localparam int CNT_W = credit_link_pkg::count_bits(DEPTH);

  logic              send, pop, credit_back, rx_wr;
  logic [DATA_W-1:0] rx_data;

  credit_sender #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .credit_ret(credit_back), .send(send)
  );

  link_pipe #(.W(DATA_W + 1), .STAGES(HOPS)) u_fwd (
    .clk(clk), .rst(rst), .d_in({send, in_data}), .d_out({rx_wr, rx_data})
  );

  credit_receiver #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst(rst), .wr_en(rx_wr), .wr_data(rx_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .pop(pop)
  );

  link_pipe #(.W(1), .STAGES(HOPS)) u_rev (
    .clk(clk), .rst(rst), .d_in(pop), .d_out(credit_back)
  );
endmodule

// File: tb/tb_credit_link.sv
module tb_credit_link;
  localparam int DW  = 8;
  localparam int N   = 3;
  localparam int CAP = 2 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] out_data;

  int tests = 0, fails = 0;
  int acc, pops, first_idx, low_cnt;
  logic last_in, last_out;
  logic [DW-1:0] next_data = '0;
  logic [DW-1:0] sb[$];

  always #10 clk = ~clk;

  credit_link #(.DATA_W(DW), .LAT(N)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic v, input logic r);
    in_valid  = v;
    in_data   = next_data;
    out_ready = r;
    #1;
    last_in  = in_valid && in_ready;
    last_out = out_valid && out_ready;
    if (last_in) begin
      sb.push_back(next_data);
      next_data = next_data + 1'b1;
      acc++;
    end
    if (last_out) begin
      pops++;
      if (sb.size() == 0) check("R7 pop with empty scoreboard", 1, 0);
      else check("R7 order/data", int'(out_data), int'(sb.pop_front()));
    end
    @(negedge clk);
  endtask

  task automatic drain(input int cycles);
    for (int i = 0; i < cycles; i++) tick(1'b0, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 in_ready after reset", int'(in_ready), 1);
    check("R1 out_valid after reset", int'(out_valid), 0);

    // R2/R3/R4: stalled consumer, producer always valid
    acc = 0; pops = 0; first_idx = -1;
    for (int i = 0; i < 4 * N; i++) begin
      if (first_idx < 0 && out_valid) first_idx = i;
      tick(1'b1, 1'b0);
    end
    check("R2 accepts with stalled consumer", acc, CAP);
    check("R2 in_ready low with no credit", int'(in_ready), 0);
    check("R4 first item latency", first_idx, N);
    check("R8 head held while stalled", int'(out_data), 0);
    check("R3 out_valid with full buffer", int'(out_valid), 1);

    // R5: one pop from the full stall, watch credit come back
    tick(1'b1, 1'b1);
    first_idx = -1;
    for (int k = 1; k <= N + 1; k++) begin
      if (k == N - 1) check("R5 ready still low one cycle early", int'(in_ready), 0);
      if (first_idx < 0 && in_ready) first_idx = k;
      if (k == N + 1) check("R5 ready low after reuse", int'(in_ready), 0);
      tick(1'b1, 1'b0);
    end
    check("R5 credit return latency", first_idx, N);

    drain(5 * N);
    check("R7 scoreboard empty after drain", sb.size(), 0);
    check("R9 in_ready after drain", int'(in_ready), 1);

    // R6: continuous traffic
    acc = 0; pops = 0; low_cnt = 0;
    for (int i = 0; i < 60; i++) begin
      if (!in_ready) low_cnt++;
      tick(1'b1, 1'b1);
    end
    check("R6 in_ready never low in streaming", low_cnt, 0);
    check("R6 accepts in streaming", acc, 60);
    check("R6 pops in streaming", pops, 60 - N);
    drain(5 * N);

    // R7: irregular patterns
    acc = 0; pops = 0;
    for (int i = 0; i < 300; i++) tick((i % 3) != 0, (i % 5) < 2 || (i % 7) == 0);
    drain(5 * N);
    check("R7 all items delivered", pops, acc);
    check("R7 scoreboard empty", sb.size(), 0);

    // R9: credits fully restored
    acc = 0;
    for (int i = 0; i < 4 * N; i++) tick(1'b1, 1'b0);
    check("R9 full credit count restored", acc, CAP);
    drain(5 * N);
    check("R7 final scoreboard empty", sb.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule